// File: doc/BRIEF.md
# Clock and Reset Controller Register Bank

This block is the software-visible register file of a power, reset and clock controller. It answers a 32-bit APB-style slave port over a 4 KiB address window and holds nine 32-bit registers. These are one oscillator setup word, three PLL divider words (PLL A, B and C), two PLL auxiliary words (PLL B and C), a core clock source select, a peripheral reset word and a clock-mux status word.

The oscillator and PLLs are not modelled. The oscillator always reports ready and every PLL always reports locked and running on internal feedback. To keep that true, writes to the oscillator and PLL divider words force those status bits high, whatever the write data holds. Accesses to offsets that hold no register, misaligned addresses and writes narrower than a full word all complete with an error response and change nothing.

Top module: `prc_regs`

## Requirements
- R1: After reset the bank reads: oscillator word 0xC000_0000 (bit 30 enable, bit 31 ready); each PLL divider word 0x8201_87C1 (R=1 in bits [5:0], F=31 in bits [14:6], Q=3 in bits [17:15], bit 25 feedback select, bit 31 lock); core clock select 0x0000_0001; PLL auxiliary words, peripheral reset word and mux status word 0.
- R2: The registers sit at these byte offsets: oscillator 0x00, PLL A divider 0x04, PLL B divider 0x0C, PLL B auxiliary 0x10, PLL C divider 0x1C, PLL C auxiliary 0x20, clock select 0x24, peripheral reset 0x28, mux status 0x2C.
- R3: A write to the oscillator word stores the data with bit 31 forced to 1.
- R4: A write to any PLL divider word stores the data with bits 25 and 31 forced to 1.
- R5: Writes to the PLL auxiliary words (bit 24 is clock enable), clock select, peripheral reset and mux status words store the data unchanged.
- R6: An access to an offset in the window that holds no register completes with pslverr_o high in its access cycle; a read returns 0 and a write changes no register.
- R7: An address with bits [1:0] not zero is an error as in R6.
- R8: A write whose pstrb_i is not all ones is an error as in R6, leaving the target unchanged.
- R9: pready_o is always 1; read data is valid in the access cycle, and a read in the cycle right after a write returns the forced stored value.
- R10: pslverr_o is only high in an access cycle, and prdata_o is 0 outside an error-free read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | 1 for write, 0 for read |
| paddr_i | input | ADDR_W | Byte address within the window |
| pwdata_i | input | DATA_W | Write data |
| pstrb_i | input | DATA_W/8 | Byte strobes; must be all ones on writes |
| prdata_o | output | DATA_W | Read data |
| pready_o | output | 1 | Transfer ready, constant 1 |
| pslverr_o | output | 1 | Error response |

## Verification
The bench builds the block with its defaults, a 12-bit address and 32-bit data, so the full 4 KiB window is addressable. That puts the gaps between registers (0x08, 0x14, 0x18) and the top word 0xFFC within reach as unmapped targets. It also allows misaligned byte addresses next to mapped words and narrow strobes on a mapped word. Writes of all zeros and all ones to the forced words show which bits the hardware owns.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int NREG = 9;

  localparam logic [31:0] OSC_FORCE  = 32'h8000_0000;
  localparam logic [31:0] PLL_FORCE  = 32'h8200_0000;
  localparam logic [31:0] OSC_RST    = 32'hC000_0000;
  // R=1, F=31, Q=3, feedback select, lock
  localparam logic [31:0] PLL_RST    = (32'd1) | (32'd31 << 6) | (32'd3 << 15) | PLL_FORCE;

  // index: 0 osc, 1 pll_a div, 2 pll_b div, 3 pll_b aux, 4 pll_c div,
  //        5 pll_c aux, 6 clk sel, 7 periph reset, 8 mux status
  function automatic logic [31:0] reg_off(int i);
    case (i)
      0: return 32'h000;
      1: return 32'h004;
      2: return 32'h00C;
      3: return 32'h010;
      4: return 32'h01C;
      5: return 32'h020;
      6: return 32'h024;
      7: return 32'h028;
      default: return 32'h02C;
    endcase
  endfunction

  function automatic logic [31:0] reg_rst(int i);
    case (i)
      0: return OSC_RST;
      1, 2, 4: return PLL_RST;
      6: return 32'h1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] reg_force(int i);
    case (i)
      0: return OSC_FORCE;
      1, 2, 4: return PLL_FORCE;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/prc_addr_dec.sv
module prc_addr_dec #(
  parameter int ADDR_W = 12,
  parameter int NREG   = prc_pkg::NREG
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o,
  output logic              hit_o
);
  // full-address compare: misaligned addresses never match
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(prc_pkg::reg_off(i));
    assign sel_o[i] = (addr_i == OFF);
  end
  assign hit_o = |sel_o;
endmodule

// File: rtl/prc_reg.sv
module prc_reg #(
  parameter int                 DATA_W    = 32,
  parameter logic [DATA_W-1:0]  RST_VAL   = '0,
  parameter logic [DATA_W-1:0]  FORCE_SET = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= wdata_i | FORCE_SET;
  end
endmodule

// File: rtl/prc_regs.sv
module prc_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [DATA_W-1:0]   pwdata_i,
  input  logic [DATA_W/8-1:0] pstrb_i,
  output logic [DATA_W-1:0]   prdata_o,
  output logic                pready_o,
  output logic                pslverr_o
);
  localparam int NREG = prc_pkg::NREG;

  logic [NREG-1:0]   sel;
  logic              hit;
  logic              access, err;
  logic [DATA_W-1:0] q [NREG];
  logic [DATA_W-1:0] rd_mux;

  prc_addr_dec #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr_i(paddr_i), .sel_o(sel), .hit_o(hit)
  );

  assign access = psel_i & penable_i;
  assign err    = ~hit | (pwrite_i & ~(&pstrb_i));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    prc_reg #(
      .DATA_W   (DATA_W),
      .RST_VAL  (DATA_W'(prc_pkg::reg_rst(i))),
      .FORCE_SET(DATA_W'(prc_pkg::reg_force(i)))
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (access & pwrite_i & ~err & sel[i]),
      .wdata_i(pwdata_i),
      .q_o    (q[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rd_mux |= q[i];
  end

  assign prdata_o  = (access & ~pwrite_i & ~err) ? rd_mux : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = access & err;
endmodule

// File: rtl/prc_regs_chk.sv
module prc_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                psel_i,
  input logic                penable_i,
  input logic                pwrite_i,
  input logic [ADDR_W-1:0]   paddr_i,
  input logic [DATA_W/8-1:0] pstrb_i,
  input logic [DATA_W-1:0]   prdata_o,
  input logic                pready_o,
  input logic                pslverr_o
);
  logic rd_ok;
  assign rd_ok = psel_i & penable_i & ~pwrite_i & ~pslverr_o;

  // R9
  pready_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) pready_o);
  // R10
  err_in_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (psel_i && penable_i));
  // R10
  idle_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && !pwrite_i) |-> (prdata_o == '0));
  // R6
  err_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pslverr_o && !pwrite_i) |-> (prdata_o == '0));
  // R7
  misalign_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && paddr_i[1:0] != 2'b00) |-> pslverr_o);
  // R8
  narrow_wr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pwrite_i && !(&pstrb_i)) |-> pslverr_o);
  // R3
  osc_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && paddr_i == ADDR_W'(12'h000)) |-> prdata_o[31]);
  // R4
  pll_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && (paddr_i == ADDR_W'(12'h004) || paddr_i == ADDR_W'(12'h00C) ||
               paddr_i == ADDR_W'(12'h01C))) |-> (prdata_o[31] && prdata_o[25]));
endmodule

bind prc_regs prc_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
  .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pstrb_i(pstrb_i),
  .prdata_o(prdata_o), .pready_o(pready_o), .pslverr_o(pslverr_o)
);

// File: tb/prc_regs_tb_top.sv
`timescale 1ns/1ps
module prc_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  prc_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .pstrb_i(pstrb),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(logic [11:0] a, logic [31:0] d, logic [3:0] s, output logic e);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1;
    #1 e = pslverr;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pstrb = '0;
  endtask

  task automatic apb_rd(logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 begin d = prdata; e = pslverr; end
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d; logic e;
    apb_rd(a, d, e);
    chk({tag, " data"}, d, exp);
    chk({tag, " err"}, {31'd0, e}, 32'd0);
  endtask

  task automatic wr_ok(string tag, logic [11:0] a, logic [31:0] d);
    logic e;
    apb_wr(a, d, 4'hF, e);
    chk({tag, " wr err"}, {31'd0, e}, 32'd0);
  endtask

  task automatic t_reset;
    // R1, R2
    rd_chk("R1 osc",      12'h000, 32'hC000_0000);
    rd_chk("R1 pll_a",    12'h004, 32'h8201_87C1);
    rd_chk("R1 pll_b",    12'h00C, 32'h8201_87C1);
    rd_chk("R1 pll_b_ax", 12'h010, 32'h0);
    rd_chk("R1 pll_c",    12'h01C, 32'h8201_87C1);
    rd_chk("R1 pll_c_ax", 12'h020, 32'h0);
    rd_chk("R1 clk_sel",  12'h024, 32'h1);
    rd_chk("R2 rst",      12'h028, 32'h0);
    rd_chk("R2 mux",      12'h02C, 32'h0);
  endtask

  task automatic t_osc;
    wr_ok("R3", 12'h000, 32'h0);
    rd_chk("R3 zero wr", 12'h000, 32'h8000_0000);
    wr_ok("R3", 12'h000, 32'h4000_1234);
    rd_chk("R3 data wr", 12'h000, 32'hC000_1234);
  endtask

  task automatic t_pll;
    wr_ok("R4", 12'h004, 32'h0);
    rd_chk("R4 pll_a zero", 12'h004, 32'h8200_0000);
    wr_ok("R4", 12'h00C, 32'h0000_1111);
    rd_chk("R4 pll_b", 12'h00C, 32'h8200_1111);
    wr_ok("R4", 12'h01C, 32'hFFFF_FFFF);
    rd_chk("R4 pll_c ones", 12'h01C, 32'hFFFF_FFFF);
  endtask

  task automatic t_plain;
    wr_ok("R5", 12'h010, 32'h0100_0000);
    rd_chk("R5 pll_b_ax", 12'h010, 32'h0100_0000);
    wr_ok("R5", 12'h020, 32'h7FFF_FFFF);
    rd_chk("R5 pll_c_ax", 12'h020, 32'h7FFF_FFFF);
    wr_ok("R5", 12'h024, 32'h0);
    rd_chk("R5 clk_sel", 12'h024, 32'h0);
    wr_ok("R5", 12'h028, 32'hA5A5_5A5A);
    rd_chk("R5 rst", 12'h028, 32'hA5A5_5A5A);
    wr_ok("R5", 12'h02C, 32'h0000_0003);
    rd_chk("R5 mux", 12'h02C, 32'h0000_0003);
    rd_chk("R5 pll_a kept", 12'h004, 32'h8200_0000);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    foreach (int_addrs[k]) begin
      apb_wr(int_addrs[k], 32'hDEAD_BEEF, 4'hF, e);
      chk("R6 wr err", {31'd0, e}, 32'd1);
      apb_rd(int_addrs[k], d, e);
      chk("R6 rd err", {31'd0, e}, 32'd1);
      chk("R6 rd data", d, 32'h0);
    end
    rd_chk("R6 rst kept", 12'h028, 32'hA5A5_5A5A);
    rd_chk("R6 pll_b kept", 12'h00C, 32'h8200_1111);
    rd_chk("R6 pll_c_ax kept", 12'h020, 32'h7FFF_FFFF);
  endtask
  logic [11:0] int_addrs [4] = '{12'h008, 12'h014, 12'h018, 12'hFFC};

  task automatic t_misalign;
    logic [31:0] d; logic e;
    apb_rd(12'h029, d, e);
    chk("R7 rd err", {31'd0, e}, 32'd1);
    chk("R7 rd data", d, 32'h0);
    apb_wr(12'h026, 32'h0000_0001, 4'hF, e);
    chk("R7 wr err", {31'd0, e}, 32'd1);
    rd_chk("R7 clk_sel kept", 12'h024, 32'h0);
  endtask

  task automatic t_strobe;
    logic e;
    apb_wr(12'h028, 32'h1111_1111, 4'b0011, e);
    chk("R8 err", {31'd0, e}, 32'd1);
    rd_chk("R8 rst kept", 12'h028, 32'hA5A5_5A5A);
    apb_wr(12'h000, 32'h0, 4'b0111, e);
    chk("R8 osc err", {31'd0, e}, 32'd1);
    rd_chk("R8 osc kept", 12'h000, 32'hC000_1234);
  endtask

  task automatic t_b2b;
    // R9, R10: write then read in the very next cycle
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = 12'h004; pwdata = 32'h0000_0042; pstrb = 4'hF;
    @(negedge clk);
    penable = 1;
    #1 begin
      chk("R9 pready wr", {31'd0, pready}, 32'd1);
      chk("R9 wr err", {31'd0, pslverr}, 32'd0);
    end
    @(negedge clk);
    penable = 0; pwrite = 0; pstrb = '0;
    #1 begin
      chk("R10 setup data", prdata, 32'h0);
      chk("R10 setup err", {31'd0, pslverr}, 32'd0);
    end
    @(negedge clk);
    penable = 1;
    #1 begin
      chk("R9 b2b data", prdata, 32'h8200_0042);
      chk("R9 pready rd", {31'd0, pready}, 32'd1);
    end
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 begin
      chk("R10 reset err", {31'd0, pslverr}, 32'd0);
      chk("R10 reset data", prdata, 32'h0);
    end
    rst_n = 1'b1;
    t_reset();
    t_osc();
    t_pll();
    t_plain();
    t_unmapped();
    t_misalign();
    t_strobe();
    t_b2b();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule